// File: doc/BRIEF.md
# In-Order Issue Scoreboard

This block sits at the issue stage of a single-issue pipeline. Four functional units hang off that stage: integer, add, multiply and divide. Each cycle decode presents one instruction. The instruction carries a valid flag, a unit class, a destination register and two source registers. The block decides in that same cycle whether the instruction may leave. When it may not, the block raises `stall`, and decode holds the instruction unchanged until `issue` is seen. Only register tags and control pass through the block. Operand values and arithmetic stay outside it.

The state is small. There is one write-pending bit for each architectural register and one busy indication for each unit. Each unit is modelled as a pipeline of (valid, tag) stages, so the block knows when each result reaches the single write-back port. That write-back clears the pending bit.

Units have these latencies: integer 1, add 1, multiply 3 and divide 4. Multiply is pipelined. Divide holds one instruction at a time. Because completion can be out of order, a reservation shift register records which future cycles already own the write-back port. An instruction that would collide with a booked slot is held back.

The divider is controlled by a two-state machine:
- `DV_IDLE` goes to `DV_RUN` when a divide is dispatched.
- `DV_RUN` counts through its latency and returns to `DV_IDLE` in the cycle after its write-back is presented.

Top module: `issue_scoreboard`

## Requirements
- R1: After reset no register is pending, the divider is idle, no write-back slot is booked, and with `in_valid` low `stall`, `issue` and `wb_valid` are all 0.
- R2: Unit classes are encoded on `in_fu` as 0 = integer, 1 = add, 2 = multiply, 3 = divide. A valid instruction with no hazard sees `issue`=1 and `stall`=0 in the cycle it is presented.
- R3: An instruction dispatched at clock edge d has its destination shown on `wb_dst` with `wb_valid`=1 in the cycle after edge d+L-1. L is 1 for integer and add, 3 for multiply and 4 for divide. Its pending bit is cleared at edge d+L.
- R4: An instruction whose source 1 or source 2 is pending is stalled. Because the pending bit clears at the write-back edge, a dependent instruction dispatches no earlier than the edge after that one.
- R5: An instruction whose destination is pending is stalled, so each register has at most one outstanding write.
- R6: A pending write to a register that a later instruction only reads as a source in an earlier instruction (write-after-read) does not delay that later instruction.
- R7: The divider is not pipelined. A second divide presented right after one dispatched at edge d dispatches at edge d+5.
- R8: The multiplier is pipelined. Independent multiplies dispatch on consecutive edges.
- R9: At most one unit writes back per cycle. An instruction whose write-back cycle is already booked is stalled until its slot is free.
- R10: `stall` equals `in_valid` and not `issue`. An instruction presented with `in_valid` low changes no state, and its destination does not become pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Presented instruction is valid |
| in_fu | input | 2 | Unit class: 0 int, 1 add, 2 mul, 3 div |
| in_dst | input | 5 | Destination register |
| in_src1 | input | 5 | First source register |
| in_src2 | input | 5 | Second source register |
| issue | output | 1 | Instruction dispatches at the coming edge |
| stall | output | 1 | Valid instruction is held this cycle |
| wb_valid | output | 1 | A result is on the write-back port |
| wb_dst | output | 5 | Register being written back |

## Verification
The bench presents short instruction pairs and triples. Each is built so that exactly one hazard is active, and the cycle each instruction leaves and the cycle its result appears are compared with values derived from the latencies.

- Dependences on source 1, on source 2 and on the destination are told apart by their different wait counts.
- A reuse of a read register confirms that write-after-read costs nothing.
- Back-to-back multiplies and divides separate a pipelined unit from a blocking one.
- A multiply followed by two integer instructions, and a divide followed by a multiply, fall onto an already booked write-back cycle, which shows that port collisions are avoided.
- An invalid instruction whose destination is later read shows that invalid input leaves no trace.

// File: rtl/sb_pkg.sv
package sb_pkg;
    typedef enum logic [1:0] {
        FU_INT = 2'd0,
        FU_ADD = 2'd1,
        FU_MUL = 2'd2,
        FU_DIV = 2'd3
    } fu_e;

    localparam int NUM_FU = 4;
endpackage

// File: rtl/sb_fu_pipe.sv
// Pipelined unit model: a chain of (valid, tag) stages, one new entry per cycle.
module sb_fu_pipe #(
    parameter int LAT   = 1,
    parameter int TAG_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [TAG_W-1:0] tag,
    output logic             wb_v,
    output logic [TAG_W-1:0] wb_tag
);
    logic [LAT-1:0]   v_q;
    logic [TAG_W-1:0] t_q [LAT];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_q <= '0;
            for (int i = 0; i < LAT; i++) t_q[i] <= '0;
        end else begin
            v_q[0] <= go;
            t_q[0] <= tag;
            for (int i = 1; i < LAT; i++) begin
                v_q[i] <= v_q[i-1];
                t_q[i] <= t_q[i-1];
            end
        end
    end

    always_comb begin
        wb_v   = v_q[LAT-1];
        wb_tag = t_q[LAT-1];
    end
endmodule

// File: rtl/sb_div_unit.sv
// Blocking divider model: one instruction at a time, held for LAT cycles.
module sb_div_unit #(
    parameter int LAT   = 4,
    parameter int TAG_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [TAG_W-1:0] tag,
    output logic             busy,
    output logic             wb_v,
    output logic [TAG_W-1:0] wb_tag
);
    localparam int CW = $clog2(LAT + 1);

    typedef enum logic {DV_IDLE = 1'b0, DV_RUN = 1'b1} dv_state_e;

    dv_state_e      st_q, st_d;
    logic [CW-1:0]  cnt_q;
    logic [TAG_W-1:0] tag_q;
    logic           last;

    assign last = (cnt_q == CW'(LAT - 1));

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            DV_IDLE: if (go)   st_d = DV_RUN;
            DV_RUN:  if (last) st_d = DV_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= DV_IDLE;
            cnt_q <= '0;
            tag_q <= '0;
        end else begin
            st_q <= st_d;
            if (go) begin
                cnt_q <= '0;
                tag_q <= tag;
            end else if (st_q == DV_RUN) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    always_comb begin
        busy   = (st_q == DV_RUN);
        wb_v   = (st_q == DV_RUN) && last;
        wb_tag = tag_q;
    end

    // R7: a new divide never enters while one is in flight
    a_r7_div_no_reentry: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> (st_q == DV_IDLE));
endmodule

// File: rtl/sb_wb_slots.sv
// Reservation of future write-back cycles: bit j = a result appears j edges from now.
module sb_wb_slots #(
    parameter int SLOTS = 5,
    parameter int LAT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             book,
    input  logic [LAT_W-1:0] lat,
    output logic             taken,
    output logic             now_busy
);
    logic [SLOTS-1:0] rv_q, rv_d;

    always_comb begin
        for (int j = 0; j < SLOTS; j++) begin
            rv_d[j] = ((j < SLOTS - 1) ? rv_q[(j + 1) % SLOTS] : 1'b0)
                    | (book && (lat == LAT_W'(j + 1)));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rv_q <= '0;
        else        rv_q <= rv_d;
    end

    always_comb begin
        taken    = (32'(lat) < SLOTS) ? rv_q[lat] : 1'b0;
        now_busy = rv_q[0];
    end
endmodule

// File: rtl/issue_scoreboard.sv
module issue_scoreboard #(
    parameter int NREG    = 32,
    parameter int LAT_INT = 1,
    parameter int LAT_ADD = 1,
    parameter int LAT_MUL = 3,
    parameter int LAT_DIV = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic [1:0] in_fu,
    input  logic [4:0] in_dst,
    input  logic [4:0] in_src1,
    input  logic [4:0] in_src2,
    output logic       issue,
    output logic       stall,
    output logic       wb_valid,
    output logic [4:0] wb_dst
);
    import sb_pkg::*;

    localparam int REG_W  = $clog2(NREG);
    localparam int MAXL_A = (LAT_INT > LAT_ADD) ? LAT_INT : LAT_ADD;
    localparam int MAXL_B = (LAT_MUL > LAT_DIV) ? LAT_MUL : LAT_DIV;
    localparam int MAXL   = (MAXL_A > MAXL_B) ? MAXL_A : MAXL_B;
    localparam int SLOTS  = MAXL + 1;
    localparam int LAT_W  = $clog2(SLOTS + 1);

    fu_e              fu;
    logic [NREG-1:0]  pend_q, pend_d;
    logic [LAT_W-1:0] lat_sel;
    logic [NUM_FU-1:0] busy_vec, go_vec, wbv;
    logic [REG_W-1:0] wbt [NUM_FU];
    logic             div_busy, slot_taken, slot_now;
    logic             hz_busy, hz_raw, hz_waw, ok;

    assign fu = fu_e'(in_fu);

    always_comb begin
        unique case (fu)
            FU_INT: lat_sel = LAT_W'(LAT_INT);
            FU_ADD: lat_sel = LAT_W'(LAT_ADD);
            FU_MUL: lat_sel = LAT_W'(LAT_MUL);
            FU_DIV: lat_sel = LAT_W'(LAT_DIV);
        endcase
    end

    assign busy_vec = {div_busy, 3'b000};

    always_comb begin
        hz_busy = busy_vec[in_fu];
        hz_raw  = pend_q[in_src1] | pend_q[in_src2];
        hz_waw  = pend_q[in_dst];
        ok      = !hz_busy && !hz_raw && !hz_waw && !slot_taken;
        issue   = in_valid && ok;
        stall   = in_valid && !ok;
        for (int k = 0; k < NUM_FU; k++) go_vec[k] = issue && (in_fu == 2'(k));
    end

    genvar k;
    generate
        for (k = 0; k < NUM_FU - 1; k++) begin : g_pipe
            localparam int L = (k == 0) ? LAT_INT : (k == 1) ? LAT_ADD : LAT_MUL;
            sb_fu_pipe #(.LAT(L), .TAG_W(REG_W)) u_pipe (
                .clk(clk), .rst_n(rst_n), .go(go_vec[k]), .tag(in_dst),
                .wb_v(wbv[k]), .wb_tag(wbt[k])
            );
        end
    endgenerate

    sb_div_unit #(.LAT(LAT_DIV), .TAG_W(REG_W)) u_div (
        .clk(clk), .rst_n(rst_n), .go(go_vec[NUM_FU-1]), .tag(in_dst),
        .busy(div_busy), .wb_v(wbv[NUM_FU-1]), .wb_tag(wbt[NUM_FU-1])
    );

    sb_wb_slots #(.SLOTS(SLOTS), .LAT_W(LAT_W)) u_slots (
        .clk(clk), .rst_n(rst_n), .book(issue), .lat(lat_sel),
        .taken(slot_taken), .now_busy(slot_now)
    );

    always_comb begin
        wb_valid = |wbv;
        wb_dst   = '0;
        for (int i = 0; i < NUM_FU; i++)
            if (wbv[i]) wb_dst = wb_dst | wbt[i];
    end

    always_comb begin
        pend_d = pend_q;
        if (wb_valid) pend_d[wb_dst] = 1'b0;
        if (issue)    pend_d[in_dst] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

    // R9: the write-back port is never shared
    a_r9_single_writer: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wbv));

    // R9: the booked slot for this cycle matches the unit that writes back
    a_r9_slot_agrees: assert property (@(posedge clk) disable iff (!rst_n)
        slot_now == wb_valid);

    // R3: every write-back retires a pending register
    a_r3_wb_was_pending: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> pend_q[wb_dst]);

    // R5: a dispatched destination is marked pending on the next cycle
    a_r5_dst_marked: assert property (@(posedge clk) disable iff (!rst_n)
        issue |=> pend_q[$past(in_dst)]);
endmodule

// File: tb/issue_scoreboard_bench.sv
module issue_scoreboard_bench;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       in_valid;
    logic [1:0] in_fu;
    logic [4:0] in_dst, in_src1, in_src2;
    logic       issue, stall, wb_valid;
    logic [4:0] wb_dst;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;
    int wb_at [32];

    localparam logic [1:0] F_INT = 2'd0, F_ADD = 2'd1, F_MUL = 2'd2, F_DIV = 2'd3;

    always #10 clk = ~clk;

    issue_scoreboard u_issue_scoreboard (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_fu(in_fu),
        .in_dst(in_dst), .in_src1(in_src1), .in_src2(in_src2),
        .issue(issue), .stall(stall), .wb_valid(wb_valid), .wb_dst(wb_dst)
    );

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) if (rst_n && wb_valid) wb_at[wb_dst] = cyc;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send(input logic [1:0] fu, input logic [4:0] d, input logic [4:0] s1,
                        input logic [4:0] s2, output int waited, output int edge_n);
        @(negedge clk);
        in_valid = 1'b1; in_fu = fu; in_dst = d; in_src1 = s1; in_src2 = s2;
        waited = 0;
        #2;
        while (!issue && waited < 40) begin
            chk(stall == 1'b1, "R10 stall while held", int'(stall), 1);
            waited++;
            @(negedge clk);
            #2;
        end
        chk(stall == 1'b0, "R10 stall low on dispatch", int'(stall), 0);
        edge_n = cyc + 1;
        @(posedge clk);
        #1 in_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        in_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        #2;
        chk(stall == 0,    "R1 stall after reset", int'(stall), 0);
        chk(issue == 0,    "R1 issue after reset", int'(issue), 0);
        chk(wb_valid == 0, "R1 wb_valid after reset", int'(wb_valid), 0);
    endtask

    task automatic t_latency();
        int w, e;
        send(F_INT, 5'd1, 5'd0, 5'd0, w, e);
        chk(w == 0, "R2 int dispatch", w, 0);
        idle(3); chk(wb_at[1] == e, "R3 int latency", wb_at[1], e);
        send(F_ADD, 5'd2, 5'd0, 5'd0, w, e);
        idle(3); chk(wb_at[2] == e, "R3 add latency", wb_at[2], e);
        send(F_MUL, 5'd3, 5'd0, 5'd0, w, e);
        idle(5); chk(wb_at[3] == e + 2, "R3 mul latency", wb_at[3], e + 2);
        send(F_DIV, 5'd4, 5'd0, 5'd0, w, e);
        idle(6); chk(wb_at[4] == e + 3, "R3 div latency", wb_at[4], e + 3);
    endtask

    task automatic t_raw();
        int w1, e1, w2, e2;
        send(F_MUL, 5'd5, 5'd0, 5'd0, w1, e1);
        send(F_INT, 5'd6, 5'd5, 5'd0, w2, e2);
        chk(w2 == 3 && e2 == e1 + 4, "R4 src1 raw wait", w2, 3);
        idle(6);
        send(F_INT, 5'd7, 5'd0, 5'd0, w1, e1);
        send(F_ADD, 5'd8, 5'd0, 5'd7, w2, e2);
        chk(w2 == 1 && e2 == e1 + 2, "R4 src2 raw wait", w2, 1);
        idle(6);
    endtask

    task automatic t_waw();
        int w1, e1, w2, e2;
        send(F_DIV, 5'd9, 5'd0, 5'd0, w1, e1);
        send(F_ADD, 5'd9, 5'd30, 5'd31, w2, e2);
        chk(w2 == 4, "R5 waw wait", w2, 4);
        idle(4);
        chk(wb_at[9] == e1 + 5, "R5 later write lands last", wb_at[9], e1 + 5);
        idle(4);
    endtask

    task automatic t_war();
        int w1, e1, w2, e2;
        send(F_MUL, 5'd10, 5'd11, 5'd0, w1, e1);
        send(F_INT, 5'd11, 5'd0, 5'd0, w2, e2);
        chk(w2 == 0, "R6 war no wait", w2, 0);
        idle(5);
        chk(wb_at[11] == e1 + 1, "R6 war write-back", wb_at[11], e1 + 1);
    endtask

    task automatic t_div_busy();
        int w1, e1, w2, e2;
        send(F_DIV, 5'd12, 5'd0, 5'd0, w1, e1);
        send(F_DIV, 5'd13, 5'd0, 5'd0, w2, e2);
        chk(e2 == e1 + 5, "R7 second divide edge", e2 - e1, 5);
        idle(7);
    endtask

    task automatic t_mul_pipe();
        int w1, e1, w2, e2;
        send(F_MUL, 5'd14, 5'd0, 5'd0, w1, e1);
        send(F_MUL, 5'd15, 5'd0, 5'd0, w2, e2);
        chk(w2 == 0 && e2 == e1 + 1, "R8 back-to-back mul", w2, 0);
        idle(5);
        chk(wb_at[15] == e1 + 3, "R8 second mul write-back", wb_at[15], e1 + 3);
    endtask

    task automatic t_wb_conflict();
        int w1, e1, w2, e2, w3, e3;
        send(F_MUL, 5'd16, 5'd0, 5'd0, w1, e1);
        send(F_INT, 5'd17, 5'd0, 5'd0, w2, e2);
        send(F_INT, 5'd18, 5'd0, 5'd0, w3, e3);
        chk(w2 == 0, "R9 free slot no wait", w2, 0);
        chk(w3 == 1 && e3 == e1 + 3, "R9 int held off booked slot", w3, 1);
        idle(5);
        chk(wb_at[16] == e1 + 2, "R9 mul kept its slot", wb_at[16], e1 + 2);
        send(F_DIV, 5'd19, 5'd0, 5'd0, w1, e1);
        send(F_MUL, 5'd20, 5'd0, 5'd0, w2, e2);
        chk(w2 == 1, "R9 mul held off divide slot", w2, 1);
        idle(7);
        chk(wb_at[20] == e1 + 4, "R9 mul write-back after divide", wb_at[20], e1 + 4);
    endtask

    task automatic t_invalid();
        int w, e;
        @(negedge clk);
        in_valid = 1'b0; in_fu = F_DIV; in_dst = 5'd21; in_src1 = 5'd0; in_src2 = 5'd0;
        repeat (3) begin
            #2;
            chk(stall == 0 && issue == 0, "R10 invalid input idle", int'(stall | issue), 0);
            @(negedge clk);
        end
        send(F_INT, 5'd22, 5'd21, 5'd0, w, e);
        chk(w == 0, "R10 invalid left no pending bit", w, 0);
        idle(4);
    endtask

    initial begin
        #(20 * 20000);
        chk(1'b0, "watchdog", 0, 1);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < 32; i++) wb_at[i] = -1;
        rst_n = 1'b0; in_valid = 1'b0; in_fu = '0; in_dst = '0; in_src1 = '0; in_src2 = '0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        t_reset();
        t_latency();
        t_raw();
        t_waw();
        t_war();
        t_div_busy();
        t_mul_pipe();
        t_wb_conflict();
        t_invalid();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule